// File: doc/BRIEF.md
# ULPI Register Access Sequencer

This block sits on the link side of an 8-bit ULPI bus. It lets a processor read and write PHY registers by means of a small control byte, and it passes PHY status bytes (RxCmd) back to software. Software sets up a register address and, for a write, a data byte. It then sets the request bit in the control byte, with the direction bit choosing read or write. The block drives the immediate-addressing TxCmd sequence on the ULPI bus, handles the bus turnaround in both directions, and reports the end of the access through a sticky completion flag.

Two clock domains are involved. The control byte, the RxCmd copy and the decoded Vbus outputs live in the processor domain. The bus sequencer runs on the ULPI clock. The request and completion levels cross between the domains through two-flop synchronisers. RxCmd bytes are carried across by a toggle handshake that keeps only the newest byte. Address, write data and direction must stay unchanged while a request is pending. The read result is held until the next read.

Top module: `ulpi_reg_seq`

## Requirements
- R1: After reset the control byte, the RxCmd copy and the read-data byte are all zero. `ulpi_data_oe` and `ulpi_stp` are low. Control bits 7:3 always read zero.
- R2: Control byte layout: bit 0 = request, bit 1 = complete, bit 2 = direction (1 read, 0 write). When software writes 1 to bit 0 with bit 2 = 0, exactly one write access follows. The link drives TxCmd {2'b10, address} until the cycle after `ulpi_nxt` is seen. It then drives the data byte until the cycle after `ulpi_nxt` is seen again. Next comes one cycle of `ulpi_stp` with data 0x00, after which the link stops driving.
- R3: A request with bit 2 = 1 runs a read. The link drives TxCmd {2'b11, address} until `ulpi_nxt`, then stops driving. The first cycle with `ulpi_dir` high is turnaround. The byte on the following cycle becomes the read data. The access ends once `ulpi_dir` is low again.
- R4: When an access ends, the complete bit is set and the request bit is cleared in the same processor clock cycle.
- R5: Only a software write of 0 to bit 1 clears the complete bit. Writing 1 to bit 1 leaves it unchanged, and it stays set for as long as software leaves it alone. Writing 0 to bit 0 has no effect.
- R6: If `ulpi_dir` is high at a clock edge, the link is not driving the bus after that edge. When this cuts off a TxCmd or data phase, the access restarts from its TxCmd once `ulpi_dir` is low. Completion is reported only after the restarted access ends.
- R7: A byte is copied to the RxCmd output when all of these hold: `ulpi_dir` is high, `ulpi_dir` was also high on the previous cycle, `ulpi_nxt` is low, and no link-started read is in progress. Turnaround bytes, bytes with `ulpi_nxt` high and read-data bytes are not copied.
- R8: When RxCmds arrive back to back, the RxCmd output ends up holding the last of them.
- R9: RxCmd bits 3:2 hold the Vbus state: 00 below session end, 01 between session end and session valid, 10/11 session valid or above. `vbus_sess_valid` is 1 for codes 10/11. `vbus_above_end` is 1 for any code other than 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-domain clock |
| cpu_rst_n | input | 1 | Processor-domain reset, active low |
| ctrl_we | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Value written to the control byte |
| reg_addr | input | 6 | PHY register address for the next access |
| reg_wdata | input | 8 | Byte to write to the PHY register |
| ctrl_rdata | output | 8 | Control byte: bit 2 direction, bit 1 complete, bit 0 request |
| reg_rdata | output | 8 | Byte returned by the last read access |
| rxcmd_raw | output | 8 | Most recent RxCmd byte |
| vbus_sess_valid | output | 1 | Vbus at or above session valid |
| vbus_above_end | output | 1 | Vbus at or above session end |
| ulpi_clk | input | 1 | ULPI clock from the PHY |
| ulpi_rst_n | input | 1 | ULPI-domain reset, active low |
| ulpi_data_i | input | 8 | ULPI data received from the PHY |
| ulpi_data_o | output | 8 | ULPI data driven by the link |
| ulpi_data_oe | output | 1 | Link drives ULPI data when high |
| ulpi_dir | input | 1 | PHY owns the bus when high |
| ulpi_nxt | input | 1 | PHY throttle / accept strobe |
| ulpi_stp | output | 1 | Link stop strobe |

## Verification
The bench runs writes in which the PHY accepts the TxCmd at once and writes in which it holds `ulpi_nxt` low for several cycles. These separate correct hold-until-accept behaviour from a sequencer that steps forward on its own. A read with a distinct turnaround byte and data byte shows whether the capture happens on the correct cycle and whether read data stays out of the RxCmd path. An abort in which the PHY takes the bus mid-TxCmd and sends an RxCmd tests retry, completion timing and RxCmd capture together. Single RxCmds covering each Vbus code, a turnaround-only burst, a byte with `ulpi_nxt` high and a back-to-back burst show what is kept and what is dropped.

// File: rtl/ulpi_seq_pkg.sv
`timescale 1ns/1ps
package ulpi_seq_pkg;
    localparam int CTRL_W    = 8;
    localparam int CTRL_REQ  = 0;
    localparam int CTRL_DONE = 1;
    localparam int CTRL_RD   = 2;
    localparam int VBUS_HI   = 3;
    localparam int VBUS_LO   = 2;

    localparam logic [1:0] TXC_REG_WR = 2'b10;
    localparam logic [1:0] TXC_REG_RD = 2'b11;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_WDATA,
        SQ_STP,
        SQ_RTURN,
        SQ_RDATA,
        SQ_RBACK
    } seq_state_e;
endpackage

// File: rtl/ulpi_seq_sync.sv
`timescale 1ns/1ps
module ulpi_seq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign d_out = pipe_q[STAGES-1];
endmodule

// File: rtl/ulpi_seq_fsm.sv
`timescale 1ns/1ps
module ulpi_seq_fsm
    import ulpi_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic              rd_sel,
    input  logic [DATA_W-3:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] data_i,
    input  logic              dir,
    input  logic              nxt,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    output logic              stp,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] hold,
    output logic              tog
);
    typedef struct packed {
        seq_state_e        state;
        logic              done;
        logic              dir_prev;
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] hold;
        logic              tog;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [DATA_W-1:0] txcmd;

    assign txcmd = {(rd_sel ? TXC_REG_RD : TXC_REG_WR), addr};

    always_comb begin
        r_d          = r_q;
        data_o       = '0;
        data_oe      = 1'b0;
        stp          = 1'b0;
        r_d.dir_prev = dir;
        if (!req_s) r_d.done = 1'b0;

        case (r_q.state)
            SQ_IDLE: begin
                if (dir) begin
                    if (r_q.dir_prev && !nxt) begin
                        r_d.hold = data_i;
                        r_d.tog  = ~r_q.tog;
                    end
                end else if (req_s && !r_q.done) begin
                    r_d.state = SQ_CMD;
                end
            end
            SQ_CMD: begin
                data_oe = 1'b1;
                data_o  = txcmd;
                if (dir)      r_d.state = SQ_IDLE;
                else if (nxt) r_d.state = rd_sel ? SQ_RTURN : SQ_WDATA;
            end
            SQ_WDATA: begin
                data_oe = 1'b1;
                data_o  = wdata;
                if (dir)      r_d.state = SQ_IDLE;
                else if (nxt) r_d.state = SQ_STP;
            end
            SQ_STP: begin
                data_oe   = 1'b1;
                stp       = 1'b1;
                r_d.state = SQ_IDLE;
                r_d.done  = 1'b1;
            end
            SQ_RTURN: begin
                if (dir) r_d.state = SQ_RDATA;
            end
            SQ_RDATA: begin
                r_d.rdata = data_i;
                r_d.state = SQ_RBACK;
            end
            SQ_RBACK: begin
                if (!dir) begin
                    r_d.state = SQ_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= SQ_IDLE;
            r_q.done     <= 1'b0;
            r_q.dir_prev <= 1'b0;
            r_q.rdata    <= '0;
            r_q.hold     <= '0;
            r_q.tog      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done  = r_q.done;
    assign rdata = r_q.rdata;
    assign hold  = r_q.hold;
    assign tog   = r_q.tog;
endmodule

// File: rtl/ulpi_seq_cpu_regs.sv
`timescale 1ns/1ps
module ulpi_seq_cpu_regs
    import ulpi_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              done_s,
    input  logic              tog_s,
    input  logic [DATA_W-1:0] hold,
    output logic              req,
    output logic              rd_sel,
    output logic              cmplt,
    output logic [DATA_W-1:0] rxcmd
);
    typedef struct packed {
        logic              req;
        logic              rd_sel;
        logic              cmplt;
        logic              done_prev;
        logic              tog_prev;
        logic [DATA_W-1:0] rxcmd;
    } cpu_regs_t;

    cpu_regs_t c_d, c_q;
    logic unused_ctrl_bits;

    assign unused_ctrl_bits = ^ctrl_wdata[CTRL_W-1:CTRL_RD+1];

    always_comb begin
        c_d           = c_q;
        c_d.done_prev = done_s;
        c_d.tog_prev  = tog_s;
        if (ctrl_we) begin
            c_d.rd_sel = ctrl_wdata[CTRL_RD];
            if (ctrl_wdata[CTRL_REQ] && !done_s) c_d.req = 1'b1;
            if (!ctrl_wdata[CTRL_DONE])          c_d.cmplt = 1'b0;
        end
        if (done_s && !c_q.done_prev) begin
            c_d.cmplt = 1'b1;
            c_d.req   = 1'b0;
        end
        if (tog_s != c_q.tog_prev) c_d.rxcmd = hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign req    = c_q.req;
    assign rd_sel = c_q.rd_sel;
    assign cmplt  = c_q.cmplt;
    assign rxcmd  = c_q.rxcmd;
endmodule

// File: rtl/ulpi_reg_seq.sv
`timescale 1ns/1ps
module ulpi_reg_seq
    import ulpi_seq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              ctrl_we,
    input  logic [7:0]        ctrl_wdata,
    input  logic [DATA_W-3:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [7:0]        ctrl_rdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] rxcmd_raw,
    output logic              vbus_sess_valid,
    output logic              vbus_above_end,
    input  logic              ulpi_clk,
    input  logic              ulpi_rst_n,
    input  logic [DATA_W-1:0] ulpi_data_i,
    output logic [DATA_W-1:0] ulpi_data_o,
    output logic              ulpi_data_oe,
    input  logic              ulpi_dir,
    input  logic              ulpi_nxt,
    output logic              ulpi_stp
);
    logic              req, rd_sel, cmplt;
    logic              req_s, done, tog;
    logic [1:0]        back_s;
    logic [DATA_W-1:0] hold;

    ulpi_seq_cpu_regs #(.DATA_W(DATA_W)) i_cpu (
        .clk        (cpu_clk),
        .rst_n      (cpu_rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .done_s     (back_s[0]),
        .tog_s      (back_s[1]),
        .hold       (hold),
        .req        (req),
        .rd_sel     (rd_sel),
        .cmplt      (cmplt),
        .rxcmd      (rxcmd_raw)
    );

    ulpi_seq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_req_sync (
        .clk   (ulpi_clk),
        .rst_n (ulpi_rst_n),
        .d_in  (req),
        .d_out (req_s)
    );

    ulpi_seq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_back_sync (
        .clk   (cpu_clk),
        .rst_n (cpu_rst_n),
        .d_in  ({tog, done}),
        .d_out (back_s)
    );

    ulpi_seq_fsm #(.DATA_W(DATA_W)) i_fsm (
        .clk     (ulpi_clk),
        .rst_n   (ulpi_rst_n),
        .req_s   (req_s),
        .rd_sel  (rd_sel),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .data_i  (ulpi_data_i),
        .dir     (ulpi_dir),
        .nxt     (ulpi_nxt),
        .data_o  (ulpi_data_o),
        .data_oe (ulpi_data_oe),
        .stp     (ulpi_stp),
        .done    (done),
        .rdata   (reg_rdata),
        .hold    (hold),
        .tog     (tog)
    );

    always_comb begin
        ctrl_rdata            = '0;
        ctrl_rdata[CTRL_REQ]  = req;
        ctrl_rdata[CTRL_DONE] = cmplt;
        ctrl_rdata[CTRL_RD]   = rd_sel;
    end

    assign vbus_sess_valid = rxcmd_raw[VBUS_HI];
    assign vbus_above_end  = |rxcmd_raw[VBUS_HI:VBUS_LO];
endmodule

// File: rtl/ulpi_reg_seq_chk.sv
`timescale 1ns/1ps
module ulpi_reg_seq_chk (
    input logic       cpu_clk,
    input logic       cpu_rst_n,
    input logic       ctrl_we,
    input logic [7:0] ctrl_wdata,
    input logic [7:0] ctrl_rdata,
    input logic       ulpi_clk,
    input logic       ulpi_rst_n,
    input logic [7:0] ulpi_data_o,
    input logic       ulpi_data_oe,
    input logic       ulpi_dir,
    input logic       ulpi_stp
);
    assert_release_on_dir_R6: assert property (@(posedge ulpi_clk) disable iff (!ulpi_rst_n)
        (ulpi_data_oe && ulpi_dir) |=> !ulpi_data_oe);

    assert_stp_one_cycle_R2: assert property (@(posedge ulpi_clk) disable iff (!ulpi_rst_n)
        ulpi_stp |=> !ulpi_stp);

    assert_stp_driven_zero_R2: assert property (@(posedge ulpi_clk) disable iff (!ulpi_rst_n)
        ulpi_stp |-> (ulpi_data_oe && ulpi_data_o == 8'h00));

    assert_done_clears_req_R4: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        $rose(ctrl_rdata[1]) |-> !ctrl_rdata[0]);

    assert_done_sticky_R5: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        $fell(ctrl_rdata[1]) |-> $past(ctrl_we && !ctrl_wdata[1]));
endmodule

bind ulpi_reg_seq ulpi_reg_seq_chk i_chk (
    .cpu_clk      (cpu_clk),
    .cpu_rst_n    (cpu_rst_n),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .ctrl_rdata   (ctrl_rdata),
    .ulpi_clk     (ulpi_clk),
    .ulpi_rst_n   (ulpi_rst_n),
    .ulpi_data_o  (ulpi_data_o),
    .ulpi_data_oe (ulpi_data_oe),
    .ulpi_dir     (ulpi_dir),
    .ulpi_stp     (ulpi_stp)
);

// File: tb/test_ulpi_reg_seq.sv
`timescale 1ns/1ps
module test_ulpi_reg_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] data_i = '0;
    logic       dir = 1'b0;
    logic       nxt = 1'b0;
    logic [7:0] ctrl_rdata, reg_rdata, rxcmd_raw, data_o;
    logic       vbus_sess_valid, vbus_above_end, data_oe, stp;

    always #2 clk = ~clk;

    ulpi_reg_seq i_ulpi_reg_seq (
        .cpu_clk(clk), .cpu_rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata),
        .reg_rdata(reg_rdata), .rxcmd_raw(rxcmd_raw), .vbus_sess_valid(vbus_sess_valid),
        .vbus_above_end(vbus_above_end), .ulpi_clk(clk), .ulpi_rst_n(rst_n),
        .ulpi_data_i(data_i), .ulpi_data_o(data_o), .ulpi_data_oe(data_oe),
        .ulpi_dir(dir), .ulpi_nxt(nxt), .ulpi_stp(stp)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] exp_txc[$];
    int txc_cnt = 0;
    logic prev_oe = 1'b0;
    logic dir_s = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // per-clock reference comparison: bus ownership, TxCmd order, reserved bits
    always @(posedge clk) dir_s <= dir;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dir_s) chk(!data_oe, "R6 link drives while PHY owns bus", data_oe, 0);
            if (data_oe && !prev_oe) begin
                txc_cnt++;
                if (exp_txc.size() == 0) chk(0, "R2 unexpected TxCmd", data_o, 0);
                else begin
                    logic [7:0] e;
                    e = exp_txc.pop_front();
                    chk(data_o == e, "R2/R3 TxCmd order", data_o, e);
                end
            end
            chk(ctrl_rdata[7:3] == 0, "R1 reserved control bits", ctrl_rdata, 0);
            prev_oe = data_oe;
        end
    end

    task automatic cpu_write(input logic [7:0] v);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        tick();
        ctrl_we = 1'b0;
        ctrl_wdata = '0;
    endtask

    task automatic wait_txcmd();
        int n = 0;
        while (!data_oe && n < 60) begin
            tick();
            n++;
        end
        chk(data_oe, "R2 access started", data_oe, 1);
    endtask

    task automatic phy_write(input logic [5:0] a, input logic [7:0] d, input int delay);
        wait_txcmd();
        chk(data_o == {2'b10, a}, "R2 write TxCmd", data_o, {2'b10, a});
        for (int i = 0; i < delay; i++) begin
            tick();
            chk(data_oe && data_o == {2'b10, a}, "R2 TxCmd held until nxt", data_o, {2'b10, a});
        end
        nxt = 1'b1; tick(); nxt = 1'b0;
        chk(data_oe && data_o == d, "R2 write data byte", data_o, d);
        tick();
        chk(data_oe && data_o == d && !stp, "R2 data held until nxt", data_o, d);
        nxt = 1'b1; tick(); nxt = 1'b0;
        chk(stp && data_oe && data_o == 8'h00, "R2 stp cycle", {stp, data_oe, data_o}, 10'h300);
        tick();
        chk(!stp && !data_oe, "R2 bus released", {stp, data_oe}, 0);
    endtask

    task automatic phy_read(input logic [5:0] a, input logic [7:0] rb);
        wait_txcmd();
        chk(data_o == {2'b11, a}, "R3 read TxCmd", data_o, {2'b11, a});
        nxt = 1'b1; tick(); nxt = 1'b0;
        chk(!data_oe, "R3 link releases for turnaround", data_oe, 0);
        dir = 1'b1; data_i = 8'hEE; tick();
        data_i = rb; tick();
        dir = 1'b0; data_i = '0; tick();
        chk(!data_oe, "R3 no drive after turnaround back", data_oe, 0);
    endtask

    task automatic wait_cmplt();
        int n = 0;
        while (!ctrl_rdata[1] && n < 40) begin
            tick();
            n++;
        end
        chk(ctrl_rdata[1], "R4 complete set", ctrl_rdata, 8'h02);
        chk(!ctrl_rdata[0], "R4 request cleared with complete", ctrl_rdata[0], 0);
    endtask

    task automatic ack_cmplt();
        cpu_write(8'h02);
        chk(ctrl_rdata[1], "R5 writing 1 keeps complete", ctrl_rdata[1], 1);
        repeat (5) tick();
        chk(ctrl_rdata[1], "R5 complete sticky", ctrl_rdata[1], 1);
        cpu_write(8'h00);
        chk(!ctrl_rdata[1], "R5 writing 0 clears complete", ctrl_rdata[1], 0);
        repeat (10) tick();
    endtask

    task automatic phy_rx(input logic [7:0] b, input bit with_nxt);
        dir = 1'b1; data_i = 8'hFF; tick();
        data_i = b; nxt = with_nxt; tick();
        dir = 1'b0; nxt = 1'b0; data_i = '0; tick();
        repeat (6) tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) tick();
        chk(ctrl_rdata == 0 && rxcmd_raw == 0 && reg_rdata == 0, "R1 reset registers",
            {ctrl_rdata, rxcmd_raw, reg_rdata}, 0);
        chk(!data_oe && !stp, "R1 reset bus outputs", {data_oe, stp}, 0);
        rst_n = 1'b1;
        repeat (3) tick();

        // write, PHY accepts at once
        reg_addr = 6'h2A; reg_wdata = 8'h5C;
        exp_txc.push_back(8'hAA);
        base = txc_cnt;
        cpu_write(8'h01);
        chk(ctrl_rdata[0], "R2 request bit set", ctrl_rdata, 1);
        phy_write(6'h2A, 8'h5C, 0);
        wait_cmplt();
        ack_cmplt();
        chk(txc_cnt - base == 1, "R2 exactly one access", txc_cnt - base, 1);

        // write 0 to request has no effect
        cpu_write(8'h00);
        repeat (8) tick();
        chk(ctrl_rdata[0] == 0 && txc_cnt - base == 1, "R5 writing 0 to request ignored",
            txc_cnt - base, 1);

        // write, PHY throttles with nxt low
        reg_addr = 6'h01; reg_wdata = 8'hF0;
        exp_txc.push_back(8'h81);
        cpu_write(8'h01);
        phy_write(6'h01, 8'hF0, 3);
        wait_cmplt();
        ack_cmplt();

        // read
        reg_addr = 6'h15;
        exp_txc.push_back(8'hD5);
        cpu_write(8'h05);
        phy_read(6'h15, 8'hA7);
        wait_cmplt();
        chk(reg_rdata == 8'hA7, "R3 read data captured", reg_rdata, 8'hA7);
        chk(rxcmd_raw == 8'h00, "R7 read bytes not taken as RxCmd", rxcmd_raw, 0);
        ack_cmplt();

        // abort during TxCmd, RxCmd inserted, then retry
        reg_addr = 6'h3F; reg_wdata = 8'h00;
        exp_txc.push_back(8'hBF);
        exp_txc.push_back(8'hBF);
        base = txc_cnt;
        cpu_write(8'h01);
        wait_txcmd();
        dir = 1'b1; tick();
        chk(!data_oe, "R6 link stops driving on abort", data_oe, 0);
        data_i = 8'h4A; tick();
        dir = 1'b0; data_i = '0; tick();
        chk(!ctrl_rdata[1], "R6 no completion after abort", ctrl_rdata[1], 0);
        phy_write(6'h3F, 8'h00, 1);
        wait_cmplt();
        chk(txc_cnt - base == 2, "R6 access retried once", txc_cnt - base, 2);
        chk(rxcmd_raw == 8'h4A, "R7 RxCmd during abort captured", rxcmd_raw, 8'h4A);
        ack_cmplt();

        // RxCmd capture and Vbus decode
        phy_rx(8'h00, 1'b0);
        chk(rxcmd_raw == 8'h00 && !vbus_sess_valid && !vbus_above_end, "R9 vbus code 00",
            {vbus_sess_valid, vbus_above_end}, 0);
        phy_rx(8'h44, 1'b0);
        chk(rxcmd_raw == 8'h44, "R7 RxCmd captured", rxcmd_raw, 8'h44);
        chk(!vbus_sess_valid && vbus_above_end, "R9 vbus code 01",
            {vbus_sess_valid, vbus_above_end}, 2'b01);
        phy_rx(8'h08, 1'b0);
        chk(vbus_sess_valid && vbus_above_end, "R9 vbus code 10",
            {vbus_sess_valid, vbus_above_end}, 2'b11);
        phy_rx(8'h33, 1'b1);
        chk(rxcmd_raw == 8'h08, "R7 byte with nxt high ignored", rxcmd_raw, 8'h08);

        // turnaround only
        dir = 1'b1; data_i = 8'hC3; tick();
        dir = 1'b0; data_i = '0; tick();
        repeat (6) tick();
        chk(rxcmd_raw == 8'h08, "R7 turnaround byte ignored", rxcmd_raw, 8'h08);

        // back-to-back burst
        dir = 1'b1; data_i = 8'hFF; tick();
        data_i = 8'h11; tick();
        data_i = 8'h22; tick();
        data_i = 8'h8C; tick();
        dir = 1'b0; data_i = '0; tick();
        repeat (6) tick();
        chk(rxcmd_raw == 8'h8C, "R8 last RxCmd of burst kept", rxcmd_raw, 8'h8C);
        chk(vbus_sess_valid && vbus_above_end, "R9 vbus code 11",
            {vbus_sess_valid, vbus_above_end}, 2'b11);

        chk(exp_txc.size() == 0, "R2 all expected TxCmds seen", exp_txc.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule